// File: doc/BRIEF.md
# ARP Reply Receiver with Binding Cache

This block sits on the receive side of an Ethernet port. It watches a byte-wide frame stream, finds frames whose ethertype marks them as ARP, and decodes the 28-byte ARP body that follows the 14-byte Ethernet header. When the body is a correctly formatted reply, and its target protocol address equals the station's own IPv4 address, the sender's IPv4-to-MAC binding is written into a small fully associative cache. The write happens on the last byte of the frame, so padding bytes before the frame end are allowed. An 8-bit counter records every ARP frame seen. A flush input empties the cache.

The transmit side asks the cache for a next-hop MAC by putting a lookup request and an IPv4 address on the lookup port. Exactly one cycle later the block returns a done pulse, a hit flag and the stored MAC. On a miss the MAC is zero and the cache is not changed. The cache holds a parameter number of entries. A reply for an address already held rewrites that entry in place. A reply for a new address takes the slot chosen by a round-robin pointer.

The receive parser is a four-state machine. PS_ETH counts header bytes 0 to 13. It goes to PS_BODY when bytes 12 and 13 hold 0x0806, and to PS_DROP otherwise. PS_BODY checks and captures bytes 14 to 41. If the frame has not ended by byte 41, PS_BODY moves on to PS_PAD. PS_PAD and PS_DROP wait for the last byte. Every state returns to PS_ETH on an accepted byte flagged last.

Top module: `arp_rx_cache`

## Requirements
- R1: After reset the ARP count is 0, lk_done and lk_hit are low, and every lookup misses.
- R2: A frame is a valid reply when all of the following hold: ethertype 0x0806 at bytes 12-13, hardware type 0x0001 at 14-15, protocol type 0x0800 at 16-17, hardware size 6 at byte 18, protocol size 4 at byte 19, opcode 0x0002 at 20-21, and target IP (bytes 38-41, most significant byte first) equal to local_ip. Such a frame stores the sender IP (bytes 28-31) bound to the sender MAC (bytes 22-27). A later lookup of that IP hits and returns that MAC.
- R3: lk_done is high exactly in the cycle after lk_req. On a miss, lk_hit is 0 and lk_mac is 0.
- R4: A frame whose ethertype is not 0x0806 is neither counted nor stored.
- R5: An ARP frame whose opcode is not 2 is counted but not stored.
- R6: A reply whose target IP differs from local_ip is counted but not stored.
- R7: A reply with a wrong hardware size or a wrong protocol type is counted but not stored.
- R8: The binding is committed on the byte flagged last. Padding after byte 41 is ignored. An ARP frame that ends before byte 41 is counted but not stored.
- R9: arp_count rises by one on the last byte of each frame with ethertype 0x0806. This includes frames that end right after the ethertype. The count wraps from 255 to 0 and holds otherwise.
- R10: flush invalidates every entry. If a flush and a commit fall in the same cycle, the flush wins and the binding is dropped.
- R11: A reply for an IP that is already cached replaces that entry's MAC and does not create a second entry.
- R12: A binding for a new IP fills slots in round-robin order. With 4 entries, the fifth distinct IP evicts the oldest insertion. An in-place update does not advance the pointer.
- R13: Cycles with rx_valid low are ignored. Parsing gives the same result with gaps between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| local_ip | input | 32 | Station IPv4 address |
| flush | input | 1 | Invalidate all cache entries |
| lk_req | input | 1 | Lookup request |
| lk_ip | input | 32 | Address to look up |
| lk_done | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_hit | output | 1 | Lookup found a binding |
| lk_mac | output | 48 | MAC bound to lk_ip, zero on a miss |
| arp_count | output | 8 | ARP frames received, wrapping |

## Verification
Replies are sent with and without trailing padding and with idle gaps between bytes. This separates the commit-at-frame-end path taken in PS_BODY from the one taken in PS_PAD. Near-miss frames each break one rule: wrong ethertype, request opcode, foreign target IP, bad hardware size, bad protocol type, or a frame cut short. These show that each field check alone blocks the store, and the ethertype check alone decides the count. A sequence of distinct and repeated sender addresses exercises in-place update, round-robin eviction and flush, including a flush on the commit cycle. A burst of short ARP frames drives the counter through its wrap.

// File: rtl/arp_rx_pkg.sv
package arp_rx_pkg;

    typedef enum logic [1:0] {
        PS_ETH  = 2'd0,
        PS_BODY = 2'd1,
        PS_PAD  = 2'd2,
        PS_DROP = 2'd3
    } parse_state_t;

    localparam int ETH_HDR_BYTES   = 14;
    localparam int ARP_BODY_BYTES  = 28;
    localparam int ARP_FRAME_BYTES = ETH_HDR_BYTES + ARP_BODY_BYTES;

    // byte offsets from the start of the frame
    localparam int OFS_ETYPE = 12;
    localparam int OFS_HTYPE = 14;
    localparam int OFS_PTYPE = 16;
    localparam int OFS_HLEN  = 18;
    localparam int OFS_PLEN  = 19;
    localparam int OFS_OPER  = 20;
    localparam int OFS_SHA   = 22;
    localparam int OFS_SPA   = 28;
    localparam int OFS_THA   = 32;
    localparam int OFS_TPA   = 38;

    localparam logic [15:0] ETYPE_ARP  = 16'h0806;
    localparam logic [15:0] HW_ETH     = 16'h0001;
    localparam logic [15:0] PROTO_IPV4 = 16'h0800;
    localparam logic [15:0] OP_REPLY   = 16'h0002;
    localparam logic [7:0]  HW_LEN     = 8'd6;
    localparam logic [7:0]  PROTO_LEN  = 8'd4;

endpackage

// File: rtl/arp_frame_parser.sv
module arp_frame_parser
    import arp_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic [31:0]      local_ip,
    output logic             wr_en,
    output logic [31:0]      wr_ip,
    output logic [47:0]      wr_mac,
    output logic [CNT_W-1:0] arp_count
);

    localparam int IDX_W = $clog2(ARP_FRAME_BYTES + 1);
    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t I_ET_HI = idx_t'(OFS_ETYPE);
    localparam idx_t I_ET_LO = idx_t'(OFS_ETYPE + 1);
    localparam idx_t I_HT0   = idx_t'(OFS_HTYPE);
    localparam idx_t I_HT1   = idx_t'(OFS_HTYPE + 1);
    localparam idx_t I_PT0   = idx_t'(OFS_PTYPE);
    localparam idx_t I_PT1   = idx_t'(OFS_PTYPE + 1);
    localparam idx_t I_HLEN  = idx_t'(OFS_HLEN);
    localparam idx_t I_PLEN  = idx_t'(OFS_PLEN);
    localparam idx_t I_OP0   = idx_t'(OFS_OPER);
    localparam idx_t I_OP1   = idx_t'(OFS_OPER + 1);
    localparam idx_t I_SHA0  = idx_t'(OFS_SHA);
    localparam idx_t I_SPA0  = idx_t'(OFS_SPA);
    localparam idx_t I_THA0  = idx_t'(OFS_THA);
    localparam idx_t I_TPA0  = idx_t'(OFS_TPA);
    localparam idx_t I_LAST  = idx_t'(ARP_FRAME_BYTES - 1);

    parse_state_t     state, state_nxt;
    idx_t             idx;
    idx_t             tpa_ofs;
    logic             etype_hi_ok;
    logic             fmt_ok;
    logic             byte_ok;
    logic             ok_nxt;
    logic             et_match;
    logic             cnt_evt;
    logic             commit;
    logic [47:0]      sha_q;
    logic [31:0]      spa_q;
    logic [CNT_W-1:0] cnt_q;

    assign tpa_ofs  = I_LAST - idx;
    assign et_match = etype_hi_ok && (rx_data == ETYPE_ARP[7:0]);

    // per-byte format check inside the ARP body
    always_comb begin
        byte_ok = 1'b1;
        case (idx)
            I_HT0:   byte_ok = (rx_data == HW_ETH[15:8]);
            I_HT1:   byte_ok = (rx_data == HW_ETH[7:0]);
            I_PT0:   byte_ok = (rx_data == PROTO_IPV4[15:8]);
            I_PT1:   byte_ok = (rx_data == PROTO_IPV4[7:0]);
            I_HLEN:  byte_ok = (rx_data == HW_LEN);
            I_PLEN:  byte_ok = (rx_data == PROTO_LEN);
            I_OP0:   byte_ok = (rx_data == OP_REPLY[15:8]);
            I_OP1:   byte_ok = (rx_data == OP_REPLY[7:0]);
            default: begin
                if (idx >= I_TPA0 && idx <= I_LAST) begin
                    byte_ok = (rx_data == local_ip[{tpa_ofs[1:0], 3'b000} +: 8]);
                end
            end
        endcase
    end

    assign ok_nxt = fmt_ok && byte_ok;

    // next state and frame-end events
    always_comb begin
        state_nxt = state;
        cnt_evt   = 1'b0;
        commit    = 1'b0;
        if (rx_valid) begin
            unique case (state)
                PS_ETH: begin
                    if (idx == I_ET_LO) begin
                        if (rx_last) begin
                            cnt_evt = et_match;
                        end else begin
                            state_nxt = et_match ? PS_BODY : PS_DROP;
                        end
                    end
                end
                PS_BODY: begin
                    if (rx_last) begin
                        cnt_evt   = 1'b1;
                        commit    = (idx == I_LAST) && ok_nxt;
                        state_nxt = PS_ETH;
                    end else if (idx == I_LAST) begin
                        state_nxt = PS_PAD;
                    end
                end
                PS_PAD: begin
                    if (rx_last) begin
                        cnt_evt   = 1'b1;
                        commit    = fmt_ok;
                        state_nxt = PS_ETH;
                    end
                end
                PS_DROP: begin
                    if (rx_last) begin
                        state_nxt = PS_ETH;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_ETH;
        end else begin
            state <= state_nxt;
        end
    end

    // byte position, format flag and captured sender fields
    always_ff @(posedge clk) begin
        if (rst) begin
            idx         <= '0;
            etype_hi_ok <= 1'b0;
            fmt_ok      <= 1'b1;
            sha_q       <= '0;
            spa_q       <= '0;
        end else if (rx_valid) begin
            if (rx_last) begin
                idx <= '0;
            end else if (state == PS_ETH || state == PS_BODY) begin
                idx <= idx + 1'b1;
            end
            if (state == PS_ETH && idx == I_ET_HI) begin
                etype_hi_ok <= (rx_data == ETYPE_ARP[15:8]);
            end
            if (state == PS_ETH) begin
                fmt_ok <= 1'b1;
            end else if (state == PS_BODY) begin
                fmt_ok <= ok_nxt;
            end
            if (state == PS_BODY && idx >= I_SHA0 && idx < I_SPA0) begin
                sha_q <= {sha_q[39:0], rx_data};
            end
            if (state == PS_BODY && idx >= I_SPA0 && idx < I_THA0) begin
                spa_q <= {spa_q[23:0], rx_data};
            end
        end
    end

    // frame counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_evt) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en     = commit;
        wr_ip     = spa_q;
        wr_mac    = sha_q;
        arp_count = cnt_q;
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_evt |=> (arp_count == $past(arp_count) + 1'b1));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_evt |=> $stable(arp_count));

    // R8
    commit_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (rx_valid && rx_last));

    // R4
    drop_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DROP) |-> !wr_en);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(state));

endmodule

// File: rtl/arp_bind_cache.sv
module arp_bind_cache #(
    parameter int N_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        wr_en,
    input  logic [31:0] wr_ip,
    input  logic [47:0] wr_mac,
    input  logic        lk_req,
    input  logic [31:0] lk_ip,
    output logic        lk_done,
    output logic        lk_hit,
    output logic [47:0] lk_mac
);

    localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_ENTRIES - 1);

    logic [31:0]          ip_q  [N_ENTRIES];
    logic [47:0]          mac_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] vld_q;
    logic [N_ENTRIES-1:0] wr_match;
    logic [N_ENTRIES-1:0] lk_match;
    logic [PTR_W-1:0]     ptr_q;
    logic [47:0]          lk_sel;
    logic                 done_q, hit_q;
    logic [47:0]          mac_out_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign wr_match[g] = vld_q[g] && (ip_q[g] == wr_ip);
        assign lk_match[g] = vld_q[g] && (ip_q[g] == lk_ip);
    end

    always_comb begin
        lk_sel = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_sel = lk_sel | mac_q[i];
            end
        end
    end

    // entry storage: flush first, then in-place update, then round-robin fill
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < N_ENTRIES; i++) begin
                ip_q[i]  <= '0;
                mac_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (wr_en) begin
            if (|wr_match) begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    if (wr_match[i]) begin
                        mac_q[i] <= wr_mac;
                    end
                end
            end else begin
                ip_q[ptr_q]  <= wr_ip;
                mac_q[ptr_q] <= wr_mac;
                vld_q[ptr_q] <= 1'b1;
                ptr_q        <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // registered lookup result
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            hit_q     <= 1'b0;
            mac_out_q <= '0;
        end else begin
            done_q <= lk_req;
            if (lk_req) begin
                hit_q     <= |lk_match;
                mac_out_q <= lk_sel;
            end
        end
    end

    always_comb begin
        lk_done = done_q;
        lk_hit  = hit_q;
        lk_mac  = mac_out_q;
    end

    // R11
    uniq_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R11
    uniq_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_match));

    // R3
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_done);

    // R3
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_done);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_done && !lk_hit) |-> (lk_mac == '0));

endmodule

// File: rtl/arp_rx_cache.sv
module arp_rx_cache #(
    parameter int N_ENTRIES = 4,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic [31:0]      local_ip,
    input  logic             flush,
    input  logic             lk_req,
    input  logic [31:0]      lk_ip,
    output logic             lk_done,
    output logic             lk_hit,
    output logic [47:0]      lk_mac,
    output logic [CNT_W-1:0] arp_count
);

    logic        wr_en;
    logic [31:0] wr_ip;
    logic [47:0] wr_mac;

    arp_frame_parser #(
        .CNT_W(CNT_W)
    ) u_parse (
        .clk       (clk),
        .rst       (rst),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .local_ip  (local_ip),
        .wr_en     (wr_en),
        .wr_ip     (wr_ip),
        .wr_mac    (wr_mac),
        .arp_count (arp_count)
    );

    arp_bind_cache #(
        .N_ENTRIES(N_ENTRIES)
    ) u_cache (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_ip   (wr_ip),
        .wr_mac  (wr_mac),
        .lk_req  (lk_req),
        .lk_ip   (lk_ip),
        .lk_done (lk_done),
        .lk_hit  (lk_hit),
        .lk_mac  (lk_mac)
    );

endmodule

// File: tb/sim_arp_rx_cache.sv
module sim_arp_rx_cache;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] MY_IP = 32'hc0a8_0509;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_last = 1'b0;
    logic [31:0] local_ip = MY_IP;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ip = '0;
    logic        lk_done;
    logic        lk_hit;
    logic [47:0] lk_mac;
    logic [7:0]  arp_count;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    int n_req = 0;
    int n_done = 0;

    logic [7:0]  fq [$];
    logic        exp_hit_q [$];
    logic [47:0] exp_mac_q [$];
    string       exp_tag_q [$];

    arp_rx_cache u0 (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_last(rx_last), .local_ip(local_ip), .flush(flush),
        .lk_req(lk_req), .lk_ip(lk_ip), .lk_done(lk_done),
        .lk_hit(lk_hit), .lk_mac(lk_mac), .arp_count(arp_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] et, input logic [15:0] op, input logic [7:0] hl,
                         input logic [15:0] pt, input logic [47:0] sm, input logic [31:0] sip,
                         input logic [31:0] tip, input int pad);
        fq.delete();
        for (int k = 0; k < 6; k++) fq.push_back(8'hff);
        for (int k = 5; k >= 0; k--) fq.push_back(sm[8*k +: 8]);
        fq.push_back(et[15:8]); fq.push_back(et[7:0]);
        fq.push_back(8'h00); fq.push_back(8'h01);
        fq.push_back(pt[15:8]); fq.push_back(pt[7:0]);
        fq.push_back(hl); fq.push_back(8'h04);
        fq.push_back(op[15:8]); fq.push_back(op[7:0]);
        for (int k = 5; k >= 0; k--) fq.push_back(sm[8*k +: 8]);
        for (int k = 3; k >= 0; k--) fq.push_back(sip[8*k +: 8]);
        for (int k = 0; k < 6; k++) fq.push_back(8'h00);
        for (int k = 3; k >= 0; k--) fq.push_back(tip[8*k +: 8]);
        for (int k = 0; k < pad; k++) fq.push_back(8'h00);
    endtask

    task automatic reply(input logic [47:0] sm, input logic [31:0] sip);
        build(16'h0806, 16'h0002, 8'd6, 16'h0800, sm, sip, MY_IP, 0);
    endtask

    // drive the frame in fq; count check tagged R9
    task automatic send(input bit gaps, input bit flush_last, input bit do_chk);
        if (fq.size() >= 14 && fq[12] == 8'h08 && fq[13] == 8'h06) exp_cnt = (exp_cnt + 1) % 256;
        for (int k = 0; k < fq.size(); k++) begin
            @(negedge clk);
            if (gaps && (k % 3 == 1)) begin
                rx_valid = 1'b0;
                rx_data  = 8'h5a;
                rx_last  = 1'b1;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = fq[k];
            rx_last  = (k == fq.size() - 1);
            flush    = flush_last && rx_last;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        flush    = 1'b0;
        if (do_chk) chk(arp_count == 8'(exp_cnt), "R9 count", 64'(arp_count), 64'(exp_cnt));
    endtask

    // driver: push expected result, issue request
    task automatic lookup(input logic [31:0] ip, input bit eh, input logic [47:0] em, input string tag);
        @(negedge clk);
        lk_req = 1'b1;
        lk_ip  = ip;
        exp_hit_q.push_back(eh);
        exp_mac_q.push_back(eh ? em : 48'h0);
        exp_tag_q.push_back(tag);
        n_req++;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // monitor: compare each result as it appears (R3 timing)
    always @(negedge clk) begin
        if (!rst && lk_done) begin
            n_done++;
            if (exp_hit_q.size() == 0) begin
                chk(1'b0, "R3 unexpected done", 64'(1), 64'(0));
            end else begin
                logic eh;
                logic [47:0] em;
                string tg;
                eh = exp_hit_q.pop_front();
                em = exp_mac_q.pop_front();
                tg = exp_tag_q.pop_front();
                chk(lk_hit == eh && lk_mac == em, tg, {15'd0, lk_hit, lk_mac}, {15'd0, eh, em});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'(0), 64'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(arp_count == 8'd0, "R1 count", 64'(arp_count), 64'(0));
        chk(lk_done == 1'b0 && lk_hit == 1'b0, "R1 lookup outputs", 64'({lk_done, lk_hit}), 64'(0));
        lookup(32'hc012_3478, 1'b0, 48'h0, "R1 empty miss");

        // R2
        reply(48'h0212_0323_0454, 32'hc012_3478);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'hc012_3478, 1'b1, 48'h0212_0323_0454, "R2 stored hit");
        // R3
        lookup(32'h0a00_0001, 1'b0, 48'h0, "R3 miss zero");
        lookup(32'hc012_3478, 1'b1, 48'h0212_0323_0454, "R3 back-to-back hit");

        // R4
        build(16'h0800, 16'h0002, 8'd6, 16'h0800, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, MY_IP, 0);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R4 non-ARP ignored");
        // R5
        build(16'h0806, 16'h0001, 8'd6, 16'h0800, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, MY_IP, 0);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R5 request not stored");
        // R6
        build(16'h0806, 16'h0002, 8'd6, 16'h0800, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, 32'hc0a8_050a, 0);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R6 foreign target");
        // R7
        build(16'h0806, 16'h0002, 8'd5, 16'h0800, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, MY_IP, 0);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R7 bad hw size");
        build(16'h0806, 16'h0002, 8'd6, 16'h86dd, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, MY_IP, 0);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R7 bad proto type");

        // R8 and R13: padded reply sent with idle gaps
        build(16'h0806, 16'h0002, 8'd6, 16'h0800, 48'h0a0b_0c0d_0e0f, 32'h0a00_0002, MY_IP, 18);
        send(1'b1, 1'b0, 1'b1);
        lookup(32'h0a00_0002, 1'b1, 48'h0a0b_0c0d_0e0f, "R8 R13 padded gapped hit");
        // R8 truncated
        reply(48'h1111_2222_3333, 32'h0a00_0003);
        while (fq.size() > 30) void'(fq.pop_back());
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0003, 1'b0, 48'h0, "R8 truncated not stored");

        // R11
        reply(48'h0212_0323_0999, 32'hc012_3478);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'hc012_3478, 1'b1, 48'h0212_0323_0999, "R11 in-place update");

        // R12: slots A,B taken, pointer at 2; C,D fill, E evicts A
        reply(48'h0000_0000_0c0c, 32'h0a00_000c);
        send(1'b0, 1'b0, 1'b1);
        reply(48'h0000_0000_0d0d, 32'h0a00_000d);
        send(1'b0, 1'b0, 1'b1);
        reply(48'h0000_0000_0e0e, 32'h0a00_000e);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'hc012_3478, 1'b0, 48'h0, "R12 oldest evicted");
        lookup(32'h0a00_0002, 1'b1, 48'h0a0b_0c0d_0e0f, "R12 second kept");
        lookup(32'h0a00_000e, 1'b1, 48'h0000_0000_0e0e, "R12 newest present");
        lookup(32'h0a00_000c, 1'b1, 48'h0000_0000_0c0c, "R12 third kept");

        // R10
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup(32'h0a00_0002, 1'b0, 48'h0, "R10 flushed");
        lookup(32'h0a00_000e, 1'b0, 48'h0, "R10 flushed newest");
        reply(48'h0000_0000_0f0f, 32'h0a00_000f);
        send(1'b0, 1'b1, 1'b1);
        lookup(32'h0a00_000f, 1'b0, 48'h0, "R10 flush beats commit");
        reply(48'h0000_0000_0101, 32'h0a00_0010);
        send(1'b0, 1'b0, 1'b1);
        lookup(32'h0a00_0010, 1'b1, 48'h0000_0000_0101, "R10 refill after flush");

        // R9 wrap with header-only ARP frames
        build(16'h0806, 16'h0002, 8'd6, 16'h0800, 48'h0, 32'h0, MY_IP, 0);
        while (fq.size() > 14) void'(fq.pop_back());
        while (exp_cnt != 255) send(1'b0, 1'b0, 1'b0);
        chk(arp_count == 8'd255, "R9 at 255", 64'(arp_count), 64'(255));
        send(1'b0, 1'b0, 1'b0);
        chk(arp_count == 8'd0, "R9 wrap", 64'(arp_count), 64'(0));

        repeat (3) @(negedge clk);
        // R3
        chk(n_done == n_req && exp_hit_q.size() == 0, "R3 done per request", 64'(n_done), 64'(n_req));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule